// File: doc/BRIEF.md
# Dual-Issue Register Rename Map Unit

This block sits at the rename stage of a two-wide in-order front end. Each clock it accepts up to two instructions. The older one is in slot 0 and the younger one is in slot 1. Each slot carries up to two architectural source registers and an optional architectural destination. There are 8 architectural registers, each a 3-bit index. The block maps them onto a 32-entry physical register file. Every source gets its current physical tag. Every destination write gets a freshly allocated physical tag, so a younger write never disturbs a value that an older reader still needs. For each destination the block also reports the tag it displaces (the "old tag"). The retirement logic hands that old tag back when the instruction commits.

Two copies of the map are held. The speculative map is updated at rename. The committed map is updated only at retirement, one instruction per cycle, in program order. A flush throws away all speculative state. It reloads the speculative map from the committed map, and it rebuilds the free mask as every physical register the committed map does not name.

The control state machine has two states. `RN_ACTIVE` is normal renaming. `RN_RECOVER` is a single quiet cycle after a flush. The transitions are:
- ACTIVE to RECOVER on `flush_i`.
- RECOVER to ACTIVE when `flush_i` is low.
- RECOVER to RECOVER on a repeated `flush_i`.
- ACTIVE to ACTIVE otherwise.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register n maps to physical register n for n = 0..7, and physical registers 8..31 are free. With no request, `stall_o` is 0.
- R2: A valid slot's source tag outputs give the speculative mapping of the named architectural registers in the same cycle. Renames and retirements take effect in the map from the next cycle.
- R3: Each writing slot of an accepted pair receives a distinct free physical register. The lowest-numbered free register goes to the oldest writing slot, and the next lowest goes to slot 1 when both write.
- R4: When slot 0 writes register d and a slot 1 source names d, that slot 1 source tag equals slot 0's new tag in the same cycle.
- R5: When slot 1 writes a register that a slot 0 source reads, slot 0 still receives the mapping from before the pair, and the pair is accepted without stall.
- R6: When both slots write the same register, both get new tags. Slot 1's old tag equals slot 0's new tag, and the map afterwards holds slot 1's new tag.
- R7: Each writing slot's old tag output equals the mapping its destination had before the pair, apart from the R6 case.
- R8: When fewer free registers exist than the pair's writing slots need, `stall_o` is 1 and neither the free mask nor the map changes. A pair with no writes never stalls for lack of free registers.
- R9: A retirement (`ret_valid_i`) writes `ret_new_tag_i` into the committed map entry `ret_dst_i` and returns `ret_old_tag_i` to the free mask from the next cycle.
- R10: `flush_i` forces `stall_o` to 1 in its own cycle and in the following `RN_RECOVER` cycle. It loads the speculative map from the committed map, including a retirement in the same cycle. The free mask becomes exactly the registers the committed map does not name.
- R11: A slot with its valid bit low allocates nothing, updates nothing, and creates no same-pair dependency, whatever its other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard speculative state and restore from the committed map |
| s0_valid_i | input | 1 | Slot 0 (older) holds an instruction |
| s0_src_a_i | input | 3 | Slot 0 first source register |
| s0_src_b_i | input | 3 | Slot 0 second source register |
| s0_dst_we_i | input | 1 | Slot 0 writes a destination |
| s0_dst_i | input | 3 | Slot 0 destination register |
| s1_valid_i | input | 1 | Slot 1 (younger) holds an instruction |
| s1_src_a_i | input | 3 | Slot 1 first source register |
| s1_src_b_i | input | 3 | Slot 1 second source register |
| s1_dst_we_i | input | 1 | Slot 1 writes a destination |
| s1_dst_i | input | 3 | Slot 1 destination register |
| ret_valid_i | input | 1 | One instruction with a destination retires |
| ret_dst_i | input | 3 | Retiring instruction's destination register |
| ret_new_tag_i | input | 5 | Physical tag it was given at rename |
| ret_old_tag_i | input | 5 | Physical tag it displaced, to be freed |
| s0_src_a_tag_o | output | 5 | Slot 0 first source physical tag |
| s0_src_b_tag_o | output | 5 | Slot 0 second source physical tag |
| s0_new_tag_o | output | 5 | Slot 0 newly allocated destination tag |
| s0_old_tag_o | output | 5 | Slot 0 displaced destination tag |
| s1_src_a_tag_o | output | 5 | Slot 1 first source physical tag |
| s1_src_b_tag_o | output | 5 | Slot 1 second source physical tag |
| s1_new_tag_o | output | 5 | Slot 1 newly allocated destination tag |
| s1_old_tag_o | output | 5 | Slot 1 displaced destination tag |
| stall_o | output | 1 | Pair not accepted this cycle |

## Verification
A corrupted speculative map entry shows up on the next lookup of that register, one cycle after the faulty update, as a wrong source or old tag. A leaked or doubled bit in the free mask shows up later. A leaked bit makes `stall_o` rise one allocation too early. A doubled bit hands out the same tag twice, which is visible when the pool is drained. A wrong restore after a flush is exposed in the first cycle after `RN_RECOVER`. At that point the lookups should return committed tags, and the allocations should start at the lowest register the committed map leaves unused.

// File: rtl/rename_pkg.sv
package rename_pkg;

    // Default geometry of the rename stage.
    localparam int RN_ARCH_REGS = 8;
    localparam int RN_PHYS_REGS = 32;

    // Control states of the rename unit.
    typedef enum logic [0:0] {
        RN_ACTIVE  = 1'b0,
        RN_RECOVER = 1'b1
    } rn_state_e;

endpackage

// File: rtl/rename_find_free.sv
module rename_find_free #(
    parameter int WIDTH = 32,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] mask_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest set bit wins: scan downward so the last hit is the smallest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
    parameter int NUM_PHYS = 32,
    parameter int NUM_ARCH = 8,
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_one_i,
    input  logic                take_two_i,
    input  logic                rel_i,
    input  logic [PHYS_W-1:0]   rel_tag_i,
    input  logic                restore_i,
    input  logic [NUM_PHYS-1:0] restore_mask_i,
    output logic                cand0_ok_o,
    output logic [PHYS_W-1:0]   cand0_o,
    output logic                cand1_ok_o,
    output logic [PHYS_W-1:0]   cand1_o
);

    logic [NUM_PHYS-1:0] free_q;
    logic [NUM_PHYS-1:0] free_d;
    logic [NUM_PHYS-1:0] second_mask;

    rename_find_free #(.WIDTH(NUM_PHYS), .IDX_W(PHYS_W)) u_first (
        .mask_i  (free_q),
        .found_o (cand0_ok_o),
        .idx_o   (cand0_o)
    );

    // Hide the first pick so the second search finds the next one up.
    always_comb begin
        second_mask = free_q;
        if (cand0_ok_o) begin
            second_mask[cand0_o] = 1'b0;
        end
    end

    rename_find_free #(.WIDTH(NUM_PHYS), .IDX_W(PHYS_W)) u_second (
        .mask_i  (second_mask),
        .found_o (cand1_ok_o),
        .idx_o   (cand1_o)
    );

    always_comb begin
        free_d = free_q;
        if (take_one_i || take_two_i) begin
            free_d[cand0_o] = 1'b0;
        end
        if (take_two_i) begin
            free_d[cand1_o] = 1'b0;
        end
        if (rel_i) begin
            free_d[rel_tag_i] = 1'b1;
        end
        if (restore_i) begin
            free_d = restore_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                free_q[i] <= (i >= NUM_ARCH);
            end
        end else begin
            free_q <= free_d;
        end
    end

    // R3: a handed-out register really was free
    a_r3_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
        (take_one_i || take_two_i) |-> (cand0_ok_o && free_q[cand0_o]));

    // R3: the second pick exists and differs from the first
    a_r3_second_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        take_two_i |-> (cand1_ok_o && free_q[cand1_o] && (cand1_o != cand0_o)));

    // R8: nothing requested means the mask holds still
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_one_i && !take_two_i && !rel_i && !restore_i) |=> $stable(free_q));

    // R9: a released register is free on the following cycle
    a_r9_release_lands: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |=> free_q[$past(rel_tag_i)]);

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 32,
    parameter int N_RD     = 6,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_RD-1:0][ARCH_W-1:0]  rd_arch_i,
    output logic [N_RD-1:0][PHYS_W-1:0]  rd_tag_o,
    input  logic                         wr0_en_i,
    input  logic [ARCH_W-1:0]            wr0_arch_i,
    input  logic [PHYS_W-1:0]            wr0_tag_i,
    input  logic                         wr1_en_i,
    input  logic [ARCH_W-1:0]            wr1_arch_i,
    input  logic [PHYS_W-1:0]            wr1_tag_i,
    input  logic                         cm_en_i,
    input  logic [ARCH_W-1:0]            cm_arch_i,
    input  logic [PHYS_W-1:0]            cm_tag_i,
    input  logic                         restore_i,
    output logic [NUM_PHYS-1:0]          cm_free_o
);

    logic [PHYS_W-1:0] spec_q [NUM_ARCH];
    logic [PHYS_W-1:0] spec_d [NUM_ARCH];
    logic [PHYS_W-1:0] cmt_q  [NUM_ARCH];
    logic [PHYS_W-1:0] cmt_d  [NUM_ARCH];

    // Lookup ports read the speculative copy.
    for (genvar k = 0; k < N_RD; k++) begin : g_rd
        assign rd_tag_o[k] = spec_q[rd_arch_i[k]];
    end

    // Committed copy moves only on retirement.
    always_comb begin
        cmt_d = cmt_q;
        if (cm_en_i) begin
            cmt_d[cm_arch_i] = cm_tag_i;
        end
    end

    // Registers named by no committed entry are the post-flush free set.
    always_comb begin
        cm_free_o = '1;
        for (int a = 0; a < NUM_ARCH; a++) begin
            cm_free_o[cmt_d[a]] = 1'b0;
        end
    end

    // Younger write is applied last so it wins on a shared destination.
    always_comb begin
        spec_d = spec_q;
        if (wr0_en_i) begin
            spec_d[wr0_arch_i] = wr0_tag_i;
        end
        if (wr1_en_i) begin
            spec_d[wr1_arch_i] = wr1_tag_i;
        end
        if (restore_i) begin
            spec_d = cmt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ARCH; a++) begin
                spec_q[a] <= PHYS_W'(a);
                cmt_q[a]  <= PHYS_W'(a);
            end
        end else begin
            spec_q <= spec_d;
            cmt_q  <= cmt_d;
        end
    end

    // R6: on a shared destination the younger tag is what remains
    a_r6_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en_i && wr1_en_i && (wr0_arch_i == wr1_arch_i) && !restore_i)
        |=> (spec_q[$past(wr1_arch_i)] == $past(wr1_tag_i)));

    // R9: a retirement reaches the committed copy
    a_r9_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en_i |=> (cmt_q[$past(cm_arch_i)] == $past(cm_tag_i)));

endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
    import rename_pkg::*;
#(
    parameter int NUM_ARCH = RN_ARCH_REGS,
    parameter int NUM_PHYS = RN_PHYS_REGS,
    localparam int ARCH_W  = $clog2(NUM_ARCH),
    localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              s0_valid_i,
    input  logic [ARCH_W-1:0] s0_src_a_i,
    input  logic [ARCH_W-1:0] s0_src_b_i,
    input  logic              s0_dst_we_i,
    input  logic [ARCH_W-1:0] s0_dst_i,
    input  logic              s1_valid_i,
    input  logic [ARCH_W-1:0] s1_src_a_i,
    input  logic [ARCH_W-1:0] s1_src_b_i,
    input  logic              s1_dst_we_i,
    input  logic [ARCH_W-1:0] s1_dst_i,
    input  logic              ret_valid_i,
    input  logic [ARCH_W-1:0] ret_dst_i,
    input  logic [PHYS_W-1:0] ret_new_tag_i,
    input  logic [PHYS_W-1:0] ret_old_tag_i,
    output logic [PHYS_W-1:0] s0_src_a_tag_o,
    output logic [PHYS_W-1:0] s0_src_b_tag_o,
    output logic [PHYS_W-1:0] s0_new_tag_o,
    output logic [PHYS_W-1:0] s0_old_tag_o,
    output logic [PHYS_W-1:0] s1_src_a_tag_o,
    output logic [PHYS_W-1:0] s1_src_b_tag_o,
    output logic [PHYS_W-1:0] s1_new_tag_o,
    output logic [PHYS_W-1:0] s1_old_tag_o,
    output logic              stall_o
);

    localparam int N_RD = 6;

    rn_state_e state_q, state_d;

    logic                        w0, w1;
    logic                        short_regs;
    logic                        go;
    logic                        take_one, take_two;
    logic                        cand0_ok, cand1_ok;
    logic [PHYS_W-1:0]           cand0, cand1;
    logic [NUM_PHYS-1:0]         cm_free;
    logic [N_RD-1:0][ARCH_W-1:0] rd_arch;
    logic [N_RD-1:0][PHYS_W-1:0] rd_tag;

    // A slot only counts as a writer when it is valid.
    assign w0 = s0_valid_i && s0_dst_we_i;
    assign w1 = s1_valid_i && s1_dst_we_i;

    assign short_regs = (w0 && w1 && !cand1_ok) || ((w0 || w1) && !cand0_ok);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RN_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RN_ACTIVE:  if (flush_i) state_d = RN_RECOVER;
            RN_RECOVER: state_d = flush_i ? RN_RECOVER : RN_ACTIVE;
        endcase
    end

    // Outputs of the controller.
    always_comb begin
        stall_o = 1'b1;
        go      = 1'b0;
        unique case (state_q)
            RN_ACTIVE: begin
                stall_o = flush_i || short_regs;
                go      = !(flush_i || short_regs);
            end
            RN_RECOVER: begin
                stall_o = 1'b1;
                go      = 1'b0;
            end
        endcase
    end

    assign take_one = go && (w0 ^ w1);
    assign take_two = go && w0 && w1;

    rename_free_list #(
        .NUM_PHYS (NUM_PHYS),
        .NUM_ARCH (NUM_ARCH),
        .PHYS_W   (PHYS_W)
    ) u_free (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_one_i     (take_one),
        .take_two_i     (take_two),
        .rel_i          (ret_valid_i),
        .rel_tag_i      (ret_old_tag_i),
        .restore_i      (flush_i),
        .restore_mask_i (cm_free),
        .cand0_ok_o     (cand0_ok),
        .cand0_o        (cand0),
        .cand1_ok_o     (cand1_ok),
        .cand1_o        (cand1)
    );

    assign rd_arch[0] = s0_src_a_i;
    assign rd_arch[1] = s0_src_b_i;
    assign rd_arch[2] = s1_src_a_i;
    assign rd_arch[3] = s1_src_b_i;
    assign rd_arch[4] = s0_dst_i;
    assign rd_arch[5] = s1_dst_i;

    rename_map_table #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .N_RD     (N_RD),
        .ARCH_W   (ARCH_W),
        .PHYS_W   (PHYS_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_arch_i  (rd_arch),
        .rd_tag_o   (rd_tag),
        .wr0_en_i   (go && w0),
        .wr0_arch_i (s0_dst_i),
        .wr0_tag_i  (s0_new_tag_o),
        .wr1_en_i   (go && w1),
        .wr1_arch_i (s1_dst_i),
        .wr1_tag_i  (s1_new_tag_o),
        .cm_en_i    (ret_valid_i),
        .cm_arch_i  (ret_dst_i),
        .cm_tag_i   (ret_new_tag_i),
        .restore_i  (flush_i),
        .cm_free_o  (cm_free)
    );

    // Older slot: plain lookups; it always gets the lowest free register.
    assign s0_src_a_tag_o = rd_tag[0];
    assign s0_src_b_tag_o = rd_tag[1];
    assign s0_new_tag_o   = cand0;
    assign s0_old_tag_o   = rd_tag[4];

    // Younger slot: bypass slot 0's fresh tag on a same-pair match.
    assign s1_new_tag_o   = w0 ? cand1 : cand0;
    assign s1_src_a_tag_o = (w0 && (s1_src_a_i == s0_dst_i)) ? cand0 : rd_tag[2];
    assign s1_src_b_tag_o = (w0 && (s1_src_b_i == s0_dst_i)) ? cand0 : rd_tag[3];
    assign s1_old_tag_o   = (w0 && (s1_dst_i == s0_dst_i)) ? cand0 : rd_tag[5];

    // R10: the recovery cycle never accepts a pair
    a_r10_recover_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RN_RECOVER) |-> stall_o);

    // R10: a flush always leads into recovery
    a_r10_flush_enters: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (state_q == RN_RECOVER));

    // R10: recovery lasts one cycle unless flushed again
    a_r10_recover_exits: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RN_RECOVER) && !flush_i) |=> (state_q == RN_ACTIVE));

    // R3: two accepted writers never share a tag
    a_r3_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && w0 && w1) |-> (s0_new_tag_o != s1_new_tag_o));

    // R8: a pair without writers is never starved
    a_r8_no_write_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RN_ACTIVE) && !flush_i && !w0 && !w1) |-> !stall_o);

endmodule

// File: tb/test_rename_map_unit.sv
`timescale 1ns/1ps
module test_rename_map_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_i = 1'b0;
    logic       s0_valid_i = 1'b0, s0_dst_we_i = 1'b0;
    logic [2:0] s0_src_a_i = '0, s0_src_b_i = '0, s0_dst_i = '0;
    logic       s1_valid_i = 1'b0, s1_dst_we_i = 1'b0;
    logic [2:0] s1_src_a_i = '0, s1_src_b_i = '0, s1_dst_i = '0;
    logic       ret_valid_i = 1'b0;
    logic [2:0] ret_dst_i = '0;
    logic [4:0] ret_new_tag_i = '0, ret_old_tag_i = '0;
    logic [4:0] s0_src_a_tag_o, s0_src_b_tag_o, s0_new_tag_o, s0_old_tag_o;
    logic [4:0] s1_src_a_tag_o, s1_src_b_tag_o, s1_new_tag_o, s1_old_tag_o;
    logic       stall_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rename_map_unit i_rename_map_unit (
        .clk, .rst_n, .flush_i,
        .s0_valid_i, .s0_src_a_i, .s0_src_b_i, .s0_dst_we_i, .s0_dst_i,
        .s1_valid_i, .s1_src_a_i, .s1_src_b_i, .s1_dst_we_i, .s1_dst_i,
        .ret_valid_i, .ret_dst_i, .ret_new_tag_i, .ret_old_tag_i,
        .s0_src_a_tag_o, .s0_src_b_tag_o, .s0_new_tag_o, .s0_old_tag_o,
        .s1_src_a_tag_o, .s1_src_b_tag_o, .s1_new_tag_o, .s1_old_tag_o,
        .stall_o
    );

    typedef struct packed {
        logic       v0, w0;
        logic [2:0] a0, b0, d0;
        logic       v1, w1;
        logic [2:0] a1, b1, d1;
        logic [4:0] ea0, eb0, en0, eo0, ea1, eb1, en1, eo1;
        logic       est;
        logic [3:0] req;
    } vec_t;

    // Walked straight after reset; each row's tags assume all rows before it.
    localparam vec_t VECS [6] = '{
        // R3: plain pair, lowest free 8 then 9
        '{1'b1,1'b1,3'd1,3'd2,3'd3, 1'b1,1'b1,3'd4,3'd5,3'd6,
          5'd1,5'd2,5'd8,5'd3, 5'd4,5'd5,5'd9,5'd6, 1'b0,4'd3},
        // R4: slot 1 reads slot 0's destination
        '{1'b1,1'b1,3'd3,3'd0,3'd0, 1'b1,1'b1,3'd0,3'd6,3'd7,
          5'd8,5'd0,5'd10,5'd0, 5'd10,5'd9,5'd11,5'd7, 1'b0,4'd4},
        // R5: slot 1 overwrites what slot 0 reads
        '{1'b1,1'b1,3'd1,3'd1,3'd2, 1'b1,1'b1,3'd5,3'd5,3'd1,
          5'd1,5'd1,5'd12,5'd2, 5'd5,5'd5,5'd13,5'd1, 1'b0,4'd5},
        // R6: both write register 4
        '{1'b1,1'b1,3'd2,3'd3,3'd4, 1'b1,1'b1,3'd4,3'd7,3'd4,
          5'd12,5'd8,5'd14,5'd4, 5'd14,5'd11,5'd15,5'd14, 1'b0,4'd6},
        // R6: map keeps the younger tag 15; R11 invalid slot 1 wants d5
        '{1'b1,1'b0,3'd4,3'd1,3'd0, 1'b0,1'b1,3'd0,3'd0,3'd5,
          5'd15,5'd13,5'd0,5'd0, 5'd0,5'd0,5'd0,5'd0, 1'b0,4'd6},
        // R11: invalid slot 0 neither allocates nor bypasses
        '{1'b0,1'b1,3'd0,3'd0,3'd2, 1'b1,1'b1,3'd2,3'd5,3'd5,
          5'd0,5'd0,5'd0,5'd0, 5'd12,5'd5,5'd16,5'd5, 1'b0,4'd11}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v0, input logic w0, input logic [2:0] a0,
                         input logic [2:0] b0, input logic [2:0] d0,
                         input logic v1, input logic w1, input logic [2:0] a1,
                         input logic [2:0] b1, input logic [2:0] d1);
        s0_valid_i = v0; s0_dst_we_i = w0; s0_src_a_i = a0; s0_src_b_i = b0; s0_dst_i = d0;
        s1_valid_i = v1; s1_dst_we_i = w1; s1_src_a_i = a1; s1_src_b_i = b1; s1_dst_i = d1;
    endtask

    task automatic retire(input logic v, input logic [2:0] d, input logic [4:0] nt,
                          input logic [4:0] ot);
        ret_valid_i = v; ret_dst_i = d; ret_new_tag_i = nt; ret_old_tag_i = ot;
    endtask

    // Next cycle: inputs change at the falling edge, outputs settle 1 ns later.
    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        step();
        rst_n = 1'b1;

        // R1: reset state, identity map, no stall
        drive(1'b1, 1'b0, 3'd5, 3'd7, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R1 stall", int'(stall_o), 0);
        chk("R1 map5", int'(s0_src_a_tag_o), 5);
        chk("R1 map7", int'(s0_src_b_tag_o), 7);

        // Vector walk (R2 lookups through every row)
        for (int k = 0; k < 6; k++) begin
            step();
            drive(VECS[k].v0, VECS[k].w0, VECS[k].a0, VECS[k].b0, VECS[k].d0,
                  VECS[k].v1, VECS[k].w1, VECS[k].a1, VECS[k].b1, VECS[k].d1);
            #1;
            chk($sformatf("R%0d row%0d stall", VECS[k].req, k), int'(stall_o), int'(VECS[k].est));
            if (VECS[k].v0) begin
                chk($sformatf("R%0d row%0d s0a", VECS[k].req, k), int'(s0_src_a_tag_o), int'(VECS[k].ea0));
                chk($sformatf("R%0d row%0d s0b", VECS[k].req, k), int'(s0_src_b_tag_o), int'(VECS[k].eb0));
            end
            if (VECS[k].v0 && VECS[k].w0) begin
                chk($sformatf("R%0d row%0d s0new", VECS[k].req, k), int'(s0_new_tag_o), int'(VECS[k].en0));
                chk($sformatf("R%0d row%0d s0old", VECS[k].req, k), int'(s0_old_tag_o), int'(VECS[k].eo0));
            end
            if (VECS[k].v1) begin
                chk($sformatf("R%0d row%0d s1a", VECS[k].req, k), int'(s1_src_a_tag_o), int'(VECS[k].ea1));
                chk($sformatf("R%0d row%0d s1b", VECS[k].req, k), int'(s1_src_b_tag_o), int'(VECS[k].eb1));
            end
            if (VECS[k].v1 && VECS[k].w1) begin
                chk($sformatf("R%0d row%0d s1new", VECS[k].req, k), int'(s1_new_tag_o), int'(VECS[k].en1));
                chk($sformatf("R%0d row%0d s1old", VECS[k].req, k), int'(s1_old_tag_o), int'(VECS[k].eo1));
            end
        end

        // R3 drain: 17..30 go out pairwise; R7 old tags on the first pair
        for (int k = 0; k < 7; k++) begin
            step();
            drive(1'b1, 1'b1, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 3'd0, 3'd0, 3'd1);
            #1;
            chk("R3 drain stall", int'(stall_o), 0);
            chk("R3 drain s0new", int'(s0_new_tag_o), 17 + 2 * k);
            chk("R3 drain s1new", int'(s1_new_tag_o), 18 + 2 * k);
            if (k == 0) begin
                chk("R7 s0old", int'(s0_old_tag_o), 10);
                chk("R7 s1old", int'(s1_old_tag_o), 13);
            end
        end

        // R8: one free register left, two needed
        step();
        drive(1'b1, 1'b1, 3'd0, 3'd0, 3'd2, 1'b1, 1'b1, 3'd0, 3'd0, 3'd3);
        #1;
        chk("R8 short stall", int'(stall_o), 1);

        // R8: the stalled pair left the map alone; R2 last drain values
        step();
        drive(1'b1, 1'b0, 3'd2, 3'd3, 3'd0, 1'b1, 1'b0, 3'd0, 3'd1, 3'd0);
        #1;
        chk("R8 stall idle", int'(stall_o), 0);
        chk("R8 map2 kept", int'(s0_src_a_tag_o), 12);
        chk("R8 map3 kept", int'(s0_src_b_tag_o), 8);
        chk("R2 map0", int'(s1_src_a_tag_o), 29);
        chk("R2 map1", int'(s1_src_b_tag_o), 30);

        // R8: a single writer still fits, takes 31
        step();
        drive(1'b1, 1'b1, 3'd0, 3'd0, 3'd6, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R8 last stall", int'(stall_o), 0);
        chk("R8 last new", int'(s0_new_tag_o), 31);
        chk("R7 last old", int'(s0_old_tag_o), 9);

        // R8: empty pool, pair without writes proceeds
        step();
        drive(1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R8 nowrite stall", int'(stall_o), 0);

        // R8: empty pool, one writer stalls
        step();
        drive(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 3'd0, 3'd0, 3'd4);
        #1;
        chk("R8 empty stall", int'(stall_o), 1);

        // R9: retire the first rename of register 3, freeing tag 3
        step();
        drive(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        retire(1'b1, 3'd3, 5'd8, 5'd3);
        step();
        retire(1'b0, 3'd0, 5'd0, 5'd0);
        drive(1'b1, 1'b1, 3'd0, 3'd0, 3'd7, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R9 freed stall", int'(stall_o), 0);
        chk("R9 freed tag", int'(s0_new_tag_o), 3);
        chk("R9 old7", int'(s0_old_tag_o), 11);

        // R9: retire register 6's first rename
        step();
        drive(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        retire(1'b1, 3'd6, 5'd9, 5'd6);

        // R10: flush with a same-cycle retirement and a pending request
        step();
        retire(1'b1, 3'd0, 5'd10, 5'd0);
        flush_i = 1'b1;
        drive(1'b1, 1'b1, 3'd0, 3'd0, 3'd5, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R10 flush stall", int'(stall_o), 1);

        step();
        retire(1'b0, 3'd0, 5'd0, 5'd0);
        flush_i = 1'b0;
        #1;
        chk("R10 recover stall", int'(stall_o), 1);

        // R10: committed map {10,1,2,8,4,5,9,7}; free starts at 0, then 3
        step();
        drive(1'b1, 1'b1, 3'd0, 3'd3, 3'd1, 1'b1, 1'b1, 3'd6, 3'd7, 3'd2);
        #1;
        chk("R10 resume stall", int'(stall_o), 0);
        chk("R10 map0", int'(s0_src_a_tag_o), 10);
        chk("R10 map3", int'(s0_src_b_tag_o), 8);
        chk("R10 map6", int'(s1_src_a_tag_o), 9);
        chk("R10 map7", int'(s1_src_b_tag_o), 7);
        chk("R10 s0new", int'(s0_new_tag_o), 0);
        chk("R10 s0old", int'(s0_old_tag_o), 1);
        chk("R10 s1new", int'(s1_new_tag_o), 3);
        chk("R10 s1old", int'(s1_old_tag_o), 2);

        step();
        drive(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
        step();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule